// File: doc/BRIEF.md
# Serpentine Reference Window Loader with Column Reuse

This block keeps a BLK x BLK reference candidate block in a register window for a processing-element array. The candidate position walks a serpentine search path. A start command loads the window one column per cycle. After that, the window follows step commands to the right, down or left. Each step fetches only the data that is new to the window. Any pixels that the current path will need again are taken from a small reuse register array.

A horizontal step first moves the lower BLK-1 pixels of the leaving column into the reuse array. Suppose a later horizontal step enters a column that the array already covers, at the same top row. That happens on the reverse pass right after a row change. In that case only the bottom pixel is read from memory. A downward step reads one new row and leaves the reuse array as it is. The reference memory is outside the block and answers in the same cycle: `rd_data` must match the request on `rd_kind`/`rd_row`/`rd_col` in the cycle the request is driven. The block does not compute distortion and does not plan the path.

Top module: `refwin_loader`

## Requirements
- R1: After a synchronous active-low reset, `blk_valid` is 0, `rd_kind` is 0 (no read), and with no start command this persists.
- R2: A start command (`cmd_op`=0) accepted at a point (y,x) gives BLK column reads (`rd_kind`=1) on consecutive cycles, at row y and columns x, x+1, ... x+BLK-1. `blk_valid` is 0 during these reads and becomes 1 in the cycle after the last read, with `pt_row`/`pt_col` equal to (y,x).
- R3: While `blk_valid` is 1, pixel (r,c) of the block on `blk_pix` is the reference pixel at (pt_row+r, pt_col+c). Pixel (r,c) sits at bits [(r*BLK+c)*PIX_W +: PIX_W].
- R4: A right step (`cmd_op`=1) or left step (`cmd_op`=3) whose entering column is not held in the reuse array reads one full column (`rd_kind`=1) at row pt_row and at the entering column (pt_col+BLK or pt_col-1). The point then moves by one column.
- R5: A down step (`cmd_op`=2) reads one row (`rd_kind`=2) at row pt_row+BLK, starting at column pt_col. The point moves down one row and the reuse array is left unchanged.
- R6: A horizontal step whose entering column matches the reuse array (same column, same top row) reads a single pixel (`rd_kind`=3) at (pt_row+BLK-1, entering column). The lower BLK-1 pixels of the column last left by a horizontal step provide the rest.
- R7: A start command empties the reuse array, so the first horizontal step after it always reads a full column.
- R8: Step commands given before any start, and any command given while the window is loading, have no effect.
- R9: Step commands may arrive on consecutive cycles. Each one is taken in its own cycle and `blk_valid` stays 1.
- R10: For every `rd_kind` value, each accepted command issues at most one memory read per cycle, and no read is issued in a cycle with no accepted command while the window is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 start, 1 step right, 2 step down, 3 step left |
| start_row | input | CW | Start point row, used with a start command |
| start_col | input | CW | Start point column, used with a start command |
| rd_kind | output | 2 | 0 none, 1 column of BLK, 2 row of BLK, 3 single pixel |
| rd_row | output | CW | Row of the first pixel requested |
| rd_col | output | CW | Column of the first pixel requested |
| rd_data | input | BLK*PIX_W | Same-cycle read data; element i is the i-th pixel down the column or along the row; pixel read uses element 0 |
| blk_valid | output | 1 | Window holds the full block for the current point |
| blk_pix | output | BLK*BLK*PIX_W | Candidate block, row-major |
| pt_row | output | CW | Current search point row |
| pt_col | output | CW | Current search point column |

## Verification
On a reverse-direction step the reuse array is read and written at the same clock edge. The entering column is assembled from the stored pixels plus one fresh pixel, while the leaving column is written over those same stored pixels. The bench provokes this with the sequence right, down, left, down, right, so both reverse steps take the single-pixel path. It judges the result by comparing every pixel of the following block with the reference image it models, and by checking that the request was a single pixel at the expected address. A restart at a point that would otherwise hit stale reuse contents checks that the array is cleared.

// File: rtl/refwin_pkg.sv
// Shared encodings for the reference window loader.
// Assumes: command and read-kind codes are fixed by the external interface.
package refwin_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_RIGHT = 2'd1,
        OP_DOWN  = 2'd2,
        OP_LEFT  = 2'd3
    } move_op_t;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_COL  = 2'd1,
        RD_ROW  = 2'd2,
        RD_PIX  = 2'd3
    } rd_kind_t;

    typedef enum logic [1:0] {
        W_HOLD = 2'd0,
        W_SHL  = 2'd1,
        W_SHR  = 2'd2,
        W_SHU  = 2'd3
    } win_op_t;
endpackage

// File: rtl/refwin_ctrl.sv
// Control for the loader: tracks the search point, the loading phase and
// the tag of the reuse array, and forms the memory request per cycle.
// Assumes: memory answers in the request cycle; the path stays in range.
module refwin_ctrl
    import refwin_pkg::*;
#(
    parameter int BLK = 4,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [CW-1:0] start_row,
    input  logic [CW-1:0] start_col,
    output logic [1:0]    rd_kind,
    output logic [CW-1:0] rd_row,
    output logic [CW-1:0] rd_col,
    output win_op_t       win_op,
    output logic          use_ra,
    output logic          ra_load,
    output logic          ra_src_left,
    output logic          blk_valid,
    output logic [CW-1:0] pt_row,
    output logic [CW-1:0] pt_col
);
    localparam int          CNT_W = $clog2(BLK + 1);
    localparam logic [CW-1:0] BLK_C = CW'(BLK);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    typedef enum logic [1:0] {ST_EMPTY, ST_FILL, ST_READY} st_t;

    st_t              state;
    logic [CNT_W-1:0] fill_cnt;
    logic             ra_ok;
    logic [CW-1:0]    ra_row;
    logic [CW-1:0]    ra_col;
    logic [CW-1:0]    ent_r;
    logic [CW-1:0]    ent_l;
    logic             hit_r;
    logic             hit_l;
    logic             accept_start;
    move_op_t         op;

    assign op           = move_op_t'(cmd_op);
    assign ent_r        = pt_col + BLK_C;
    assign ent_l        = pt_col - ONE_C;
    assign hit_r        = ra_ok && (ra_col == ent_r) && (ra_row == pt_row);
    assign hit_l        = ra_ok && (ra_col == ent_l) && (ra_row == pt_row);
    assign accept_start = cmd_valid && (op == OP_START) && (state != ST_FILL);
    assign blk_valid    = (state == ST_READY);

    // Request and datapath steering for the current cycle.
    always_comb begin
        rd_kind     = RD_NONE;
        rd_row      = '0;
        rd_col      = '0;
        win_op      = W_HOLD;
        use_ra      = 1'b0;
        ra_load     = 1'b0;
        ra_src_left = 1'b0;
        if (state == ST_FILL) begin
            rd_kind = RD_COL;
            rd_row  = pt_row;
            rd_col  = pt_col + CW'(fill_cnt);
            win_op  = W_SHL;
        end else if (state == ST_READY && cmd_valid) begin
            case (op)
                OP_RIGHT: begin
                    win_op      = W_SHL;
                    ra_load     = 1'b1;
                    ra_src_left = 1'b1;
                    use_ra      = hit_r;
                    rd_col      = ent_r;
                    rd_kind     = hit_r ? RD_PIX : RD_COL;
                    rd_row      = hit_r ? pt_row + BLK_C - ONE_C : pt_row;
                end
                OP_LEFT: begin
                    win_op  = W_SHR;
                    ra_load = 1'b1;
                    use_ra  = hit_l;
                    rd_col  = ent_l;
                    rd_kind = hit_l ? RD_PIX : RD_COL;
                    rd_row  = hit_l ? pt_row + BLK_C - ONE_C : pt_row;
                end
                OP_DOWN: begin
                    win_op  = W_SHU;
                    rd_kind = RD_ROW;
                    rd_row  = pt_row + BLK_C;
                    rd_col  = pt_col;
                end
                default: ;
            endcase
        end
    end

    // Phase, search point and reuse tag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_EMPTY;
            fill_cnt <= '0;
            pt_row   <= '0;
            pt_col   <= '0;
            ra_ok    <= 1'b0;
            ra_row   <= '0;
            ra_col   <= '0;
        end else if (accept_start) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
            pt_row   <= start_row;
            pt_col   <= start_col;
            ra_ok    <= 1'b0;
        end else if (state == ST_FILL) begin
            fill_cnt <= fill_cnt + CNT_W'(1);
            if (fill_cnt == CNT_W'(BLK - 1)) begin
                state <= ST_READY;
            end
        end else if (state == ST_READY && cmd_valid) begin
            case (op)
                OP_RIGHT: begin
                    pt_col <= pt_col + ONE_C;
                    ra_ok  <= 1'b1;
                    ra_col <= pt_col;
                    ra_row <= pt_row + ONE_C;
                end
                OP_LEFT: begin
                    pt_col <= pt_col - ONE_C;
                    ra_ok  <= 1'b1;
                    ra_col <= pt_col + BLK_C - ONE_C;
                    ra_row <= pt_row + ONE_C;
                end
                OP_DOWN: pt_row <= pt_row + ONE_C;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/refwin_window.sv
// BLK x BLK pixel window register. Shifts left, right or up, filling the
// vacated column or row from new_vec.
// Assumes: new_vec element i is top-to-bottom for columns, left-to-right for rows.
module refwin_window
    import refwin_pkg::*;
#(
    parameter int BLK   = 4,
    parameter int PIX_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  win_op_t                    win_op,
    input  logic [BLK*PIX_W-1:0]       new_vec,
    output logic [BLK*BLK*PIX_W-1:0]   blk_pix
);
    logic [PIX_W-1:0] win [BLK][BLK];

    // Window shift according to the step kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < BLK; r++)
                for (int c = 0; c < BLK; c++)
                    win[r][c] <= '0;
        end else begin
            for (int r = 0; r < BLK; r++) begin
                for (int c = 0; c < BLK; c++) begin
                    case (win_op)
                        W_SHL: win[r][c] <= (c < BLK - 1) ? win[r][c+1]
                                          : new_vec[r*PIX_W +: PIX_W];
                        W_SHR: win[r][c] <= (c > 0) ? win[r][c-1]
                                          : new_vec[r*PIX_W +: PIX_W];
                        W_SHU: win[r][c] <= (r < BLK - 1) ? win[r+1][c]
                                          : new_vec[c*PIX_W +: PIX_W];
                        default: ;
                    endcase
                end
            end
        end
    end

    for (genvar gr = 0; gr < BLK; gr++) begin : g_row
        for (genvar gc = 0; gc < BLK; gc++) begin : g_col
            assign blk_pix[(gr*BLK+gc)*PIX_W +: PIX_W] = win[gr][gc];
        end
    end
endmodule

// File: rtl/refwin_reuse.sv
// Reuse register array: keeps the lower BLK-1 pixels of a column that
// leaves the window on a horizontal step.
// Assumes: the tag of the stored column is kept by the controller.
module refwin_reuse #(
    parameter int BLK   = 4,
    parameter int PIX_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [BLK*PIX_W-1:0]       leave_col,
    output logic [(BLK-1)*PIX_W-1:0]   ra_pix
);
    // Capture rows 1..BLK-1 of the leaving column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_pix <= '0;
        end else if (load) begin
            ra_pix <= leave_col[BLK*PIX_W-1:PIX_W];
        end
    end
endmodule

// File: rtl/refwin_loader.sv
// Top of the column-reuse reference window loader. Joins the controller,
// the window register and the reuse array, and builds the entering column
// from memory data or from reuse pixels plus one fresh pixel.
// Assumes: rd_data is valid in the same cycle as the request.
module refwin_loader
    import refwin_pkg::*;
#(
    parameter int BLK   = 4,
    parameter int PIX_W = 8,
    parameter int CW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [CW-1:0]            start_row,
    input  logic [CW-1:0]            start_col,
    output logic [1:0]               rd_kind,
    output logic [CW-1:0]            rd_row,
    output logic [CW-1:0]            rd_col,
    input  logic [BLK*PIX_W-1:0]     rd_data,
    output logic                     blk_valid,
    output logic [BLK*BLK*PIX_W-1:0] blk_pix,
    output logic [CW-1:0]            pt_row,
    output logic [CW-1:0]            pt_col
);
    win_op_t                  win_op;
    logic                     use_ra;
    logic                     ra_load;
    logic                     ra_src_left;
    logic [(BLK-1)*PIX_W-1:0] ra_pix;
    logic [BLK*PIX_W-1:0]     left_col;
    logic [BLK*PIX_W-1:0]     right_col;
    logic [BLK*PIX_W-1:0]     leave_col;
    logic [BLK*PIX_W-1:0]     new_vec;

    refwin_ctrl #(.BLK(BLK), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .start_row(start_row), .start_col(start_col),
        .rd_kind(rd_kind), .rd_row(rd_row), .rd_col(rd_col),
        .win_op(win_op), .use_ra(use_ra), .ra_load(ra_load),
        .ra_src_left(ra_src_left), .blk_valid(blk_valid),
        .pt_row(pt_row), .pt_col(pt_col)
    );

    refwin_window #(.BLK(BLK), .PIX_W(PIX_W)) u_win (
        .clk(clk), .rst_n(rst_n), .win_op(win_op),
        .new_vec(new_vec), .blk_pix(blk_pix)
    );

    refwin_reuse #(.BLK(BLK), .PIX_W(PIX_W)) u_reuse (
        .clk(clk), .rst_n(rst_n), .load(ra_load),
        .leave_col(leave_col), .ra_pix(ra_pix)
    );

    for (genvar gr = 0; gr < BLK; gr++) begin : g_edge
        assign left_col[gr*PIX_W +: PIX_W]  = blk_pix[(gr*BLK)*PIX_W +: PIX_W];
        assign right_col[gr*PIX_W +: PIX_W] = blk_pix[(gr*BLK+BLK-1)*PIX_W +: PIX_W];
        if (gr < BLK - 1) begin : g_top
            assign new_vec[gr*PIX_W +: PIX_W] =
                use_ra ? ra_pix[gr*PIX_W +: PIX_W] : rd_data[gr*PIX_W +: PIX_W];
        end else begin : g_bot
            assign new_vec[gr*PIX_W +: PIX_W] =
                use_ra ? rd_data[PIX_W-1:0] : rd_data[gr*PIX_W +: PIX_W];
        end
    end

    assign leave_col = ra_src_left ? left_col : right_col;
endmodule

// File: rtl/refwin_loader_chk.sv
// Property checker for refwin_loader, bound to every instance.
// Assumes: encodings of refwin_pkg on cmd_op and rd_kind.
module refwin_loader_chk #(
    parameter int BLK = 4,
    parameter int CW  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic [1:0]    rd_kind,
    input logic [CW-1:0] rd_row,
    input logic [CW-1:0] rd_col,
    input logic          blk_valid,
    input logic [CW-1:0] pt_row,
    input logic [CW-1:0] pt_col
);
    localparam logic [CW-1:0] BLK_C = CW'(BLK);

    p_fill_reads_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_valid && rd_kind != 2'd0) |-> rd_kind == 2'd1);

    p_fill_runs_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_valid && rd_kind == 2'd1) |=> (rd_kind == 2'd1 || blk_valid));

    p_right_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && cmd_valid && cmd_op == 2'd1) |=>
        (pt_col == $past(pt_col) + CW'(1) && pt_row == $past(pt_row)));

    p_down_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && cmd_valid && cmd_op == 2'd2) |->
        (rd_kind == 2'd2 && rd_row == pt_row + BLK_C && rd_col == pt_col));

    p_down_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && cmd_valid && cmd_op == 2'd2) |=>
        (pt_row == $past(pt_row) + CW'(1) && pt_col == $past(pt_col)));

    p_pix_on_horiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == 2'd3) |-> (blk_valid && cmd_valid && cmd_op[0]));

    p_valid_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && cmd_valid && cmd_op != 2'd0) |=> blk_valid);

    p_no_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !cmd_valid) |-> rd_kind == 2'd0);
endmodule

bind refwin_loader refwin_loader_chk #(.BLK(BLK), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rd_kind(rd_kind), .rd_row(rd_row), .rd_col(rd_col),
    .blk_valid(blk_valid), .pt_row(pt_row), .pt_col(pt_col)
);

// File: tb/test_refwin_loader.sv
module test_refwin_loader;
    localparam int BLK   = 4;
    localparam int PIX_W = 8;
    localparam int CW    = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     cmd_valid = 1'b0;
    logic [1:0]               cmd_op = 2'd0;
    logic [CW-1:0]            start_row = '0;
    logic [CW-1:0]            start_col = '0;
    logic [1:0]               rd_kind;
    logic [CW-1:0]            rd_row;
    logic [CW-1:0]            rd_col;
    logic [BLK*PIX_W-1:0]     rd_data;
    logic                     blk_valid;
    logic [BLK*BLK*PIX_W-1:0] blk_pix;
    logic [CW-1:0]            pt_row;
    logic [CW-1:0]            pt_col;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    refwin_loader #(.BLK(BLK), .PIX_W(PIX_W), .CW(CW)) i_refwin_loader (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .start_row(start_row), .start_col(start_col),
        .rd_kind(rd_kind), .rd_row(rd_row), .rd_col(rd_col),
        .rd_data(rd_data), .blk_valid(blk_valid), .blk_pix(blk_pix),
        .pt_row(pt_row), .pt_col(pt_col)
    );

    function automatic logic [PIX_W-1:0] ref_pix(input int r, input int c);
        return PIX_W'(r * 29 + c * 13 + 7);
    endfunction

    // Reference memory model, answers in the request cycle.
    always_comb begin
        for (int i = 0; i < BLK; i++) begin
            case (rd_kind)
                2'd1: rd_data[i*PIX_W +: PIX_W] = ref_pix(int'(rd_row) + i, int'(rd_col));
                2'd2: rd_data[i*PIX_W +: PIX_W] = ref_pix(int'(rd_row), int'(rd_col) + i);
                2'd3: rd_data[i*PIX_W +: PIX_W] = (i == 0) ? ref_pix(int'(rd_row), int'(rd_col)) : '0;
                default: rd_data[i*PIX_W +: PIX_W] = '0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_req(input int ek, input int er, input int ec, input string req);
        chk(int'(rd_kind) == ek, req, "rd_kind", int'(rd_kind), ek);
        if (ek != 0) begin
            chk(int'(rd_row) == er, req, "rd_row", int'(rd_row), er);
            chk(int'(rd_col) == ec, req, "rd_col", int'(rd_col), ec);
        end
    endtask

    // R3: whole block against the reference image at the expected point.
    task automatic chk_blk(input int er, input int ec, input string req);
        int first_bad = -1;
        int act_v = 0;
        int exp_v = 0;
        chk(blk_valid == 1'b1, req, "blk_valid", int'(blk_valid), 1);
        chk(int'(pt_row) == er, req, "pt_row", int'(pt_row), er);
        chk(int'(pt_col) == ec, req, "pt_col", int'(pt_col), ec);
        for (int r = 0; r < BLK; r++) begin
            for (int c = 0; c < BLK; c++) begin
                if (first_bad < 0 &&
                    blk_pix[(r*BLK+c)*PIX_W +: PIX_W] != ref_pix(er + r, ec + c)) begin
                    first_bad = r * BLK + c;
                    act_v = int'(blk_pix[(r*BLK+c)*PIX_W +: PIX_W]);
                    exp_v = int'(ref_pix(er + r, ec + c));
                end
            end
        end
        chk(first_bad < 0, {req, " R3"}, "blk_pix", act_v, exp_v);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(blk_valid == 1'b0, "R1", "blk_valid after reset", int'(blk_valid), 0);
        chk_req(0, 0, 0, "R1");
    endtask

    // R8: steps before any start do nothing.
    task automatic t_step_before_start;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'd1;
        #1;
        chk_req(0, 0, 0, "R8");
        @(posedge clk);
        #1;
        chk(blk_valid == 1'b0, "R8", "blk_valid after early step", int'(blk_valid), 0);
        @(negedge clk);
        cmd_op = 2'd2;
        @(posedge clk);
        #1;
        chk(blk_valid == 1'b0, "R8", "blk_valid after early down", int'(blk_valid), 0);
        chk(int'(pt_row) == 0, "R8", "pt_row after early down", int'(pt_row), 0);
        cmd_valid = 1'b0;
    endtask

    // R2 start and fill; a step is injected mid-fill to check R8.
    task automatic t_start(input int sr, input int sc, input bit poke);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'd0;
        start_row = CW'(sr);
        start_col = CW'(sc);
        @(posedge clk);
        for (int k = 0; k < BLK; k++) begin
            @(negedge clk);
            cmd_valid = poke && (k == 1);
            cmd_op    = 2'd1;
            #1;
            chk_req(1, sr, sc + k, "R2");
            chk(blk_valid == 1'b0, "R2", "blk_valid during fill", int'(blk_valid), 0);
            @(posedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk_blk(sr, sc, poke ? "R8" : "R2");
    endtask

    // One step command: check request in-cycle, then the new point and block.
    task automatic t_step(input int op, input int ek, input int er, input int ec,
                          input int nr, input int nc, input string req);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        #1;
        chk_req(ek, er, ec, req);
        @(posedge clk);
        #1;
        chk_blk(nr, nc, req);
    endtask

    task automatic t_idle;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk_req(0, 0, 0, "R10");
        @(posedge clk);
        #1;
        chk(blk_valid == 1'b1, "R10", "blk_valid while idle", int'(blk_valid), 1);
    endtask

    // Serpentine: right, down, reverse left, down, reverse right, right (back to back).
    task automatic t_serpentine;
        t_step(1, 1, 0, 7, 0, 4, "R4");
        t_step(2, 2, 4, 4, 1, 4, "R5");
        t_step(3, 3, 4, 3, 1, 3, "R6");
        t_step(2, 2, 5, 3, 2, 3, "R5");
        t_step(1, 3, 5, 7, 2, 4, "R6");
        t_step(1, 1, 2, 8, 2, 5, "R9");
        t_idle();
    endtask

    // R7: restart where stale reuse contents would hit.
    task automatic t_restart_clears;
        t_start(3, 5, 1'b0);
        t_step(3, 1, 3, 4, 3, 4, "R7");
        t_step(3, 1, 3, 3, 3, 3, "R4");
        t_idle();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_step_before_start();
        t_start(0, 3, 1'b1);
        t_serpentine();
        t_restart_clears();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule